// File: doc/BRIEF.md
# Write-Gated Two-Wire Register Slave

This block is a two-wire serial slave that sits on an SCL/SDA bus and exposes two 8-bit on-chip registers to an external master: a control register and a fault register. Both bus lines are brought into the core clock domain through synchronizers. The block detects start and stop conditions, shifts bytes in and out, and drives SDA low for acknowledges and for read data. The pad drive is open-drain, so `sda_oe_o` high means SDA is pulled low.

The master first sends a slave byte. It holds a fixed 4-bit device code, two zero bits, the ninth address bit (A8) and the direction bit. A word-address byte follows. A8 picks the register: 1 selects the control register and 0 selects the fault register. The only word address that is accepted is 0xFF. A write is committed only when the stop condition arrives straight after the acknowledge of the data byte. Three things gate a write: the write-enable bit held in the control register, the write-protect input, and that exact frame shape. A read is a dummy write that loads the word address, then a repeated start and a slave byte with the direction bit set.

Top module: `twi_regslave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), both registers read 0x00, and the write-enable bit (control register bit 1) is 0.
- R2: A slave byte is acknowledged only when its bits 7..4 are 1011 and bits 3..2 are 00. Bit 1 is A8 and bit 0 is the direction bit (1 = read, 0 = write). Any other slave byte gets no acknowledge and changes nothing.
- R3: Word address 0xFF is acknowledged. Any other word address is not acknowledged, a write that follows it changes nothing, and a read from it returns 0xFF.
- R4: With write-protect low and the enable bit at 1, a well-formed byte write with A8 = 1 loads the control register, and one with A8 = 0 loads the fault register. The data byte is acknowledged and the value appears after the stop.
- R5: While control bit 1 is 0, a write to the fault register is refused, and a write to the control register changes only bit 1.
- R6: While `wp_i` is high, no write changes either register, including bit 1.
- R7: A write commits only when the stop follows directly after the ninth clock of the data byte. A stop inside the data byte, extra clocks after it, or a repeated start instead of the stop all discard the write.
- R8: A random read returns, MSB first, the register chosen by A8 of the read slave byte and the stored word address. SDA changes only while SCL is low.
- R9: When the master does not acknowledge read data, the slave releases SDA and stays released until the next start. When the master acknowledges, the same byte is sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| wp_i | input | 1 | Write protect, high blocks every write |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ctrl_o | output | 8 | Control register contents (bit 1 = write enable) |
| fault_o | output | 8 | Fault register contents |

## Verification
The hardest case to reach from the ports is a frame that is complete up to the data acknowledge but then ends in the wrong way. Examples are a stop that lands a few bits into the data byte, a ninth clock followed by more clocks, or a repeated start where the stop belongs. The master model in the bench can cut a frame at each of these points, and the bench checks that neither register moves. These cut frames are mixed into seeded random traffic that also varies the write-protect level, A8, the word address and the enable bit. This way the refusal paths meet every state of the enable latch.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_WDONE,
    S_TX,
    S_MACK
  } fsm_t;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WADDR,
    PH_WDATA
  } phase_t;
endpackage

// File: rtl/twi_pin_sync.sv
module twi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_prev;
  logic              sda_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_q[0] <= 1'b1;
            sda_q[0] <= 1'b1;
          end else begin
            scl_q[0] <= scl_i;
            sda_q[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_q[g] <= 1'b1;
            sda_q[g] <= 1'b1;
          end else begin
            scl_q[g] <= scl_q[g-1];
            sda_q[g] <= sda_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = ~scl_prev & scl_s;
  assign scl_fall  = scl_prev & ~scl_s;
  assign start_det = scl_prev & scl_s & sda_prev & ~sda_s;
  assign stop_det  = scl_prev & scl_s & ~sda_prev & sda_s;
endmodule

// File: rtl/twi_frame.sv
module twi_frame
  import twi_pkg::*;
#(
  parameter logic [3:0]        DEV_CODE = 4'b1011,
  parameter logic [BYTE_W-1:0] REG_ADDR = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_oe,
  output logic              commit,
  output logic              a8,
  output logic [BYTE_W-1:0] waddr,
  output logic [BYTE_W-1:0] wdata
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  fsm_t              st_q, st_d, nxt_q, nxt_d;
  phase_t            ph_q, ph_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              a8_q, a8_d;
  logic              mack_q, mack_d;
  logic [BYTE_W-1:0] wa_q, wa_d;
  logic [BYTE_W-1:0] wd_q, wd_d;
  logic              dev_ok;

  assign dev_ok = (sh_q[7:4] == DEV_CODE) && (sh_q[3:2] == 2'b00);

  always_comb begin
    st_d   = st_q;
    nxt_d  = nxt_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    oe_d   = oe_q;
    a8_d   = a8_q;
    mack_d = mack_q;
    wa_d   = wa_q;
    wd_d   = wd_q;
    commit = 1'b0;
    if (start_det) begin
      st_d  = S_RX;
      ph_d  = PH_DEV;
      bit_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      commit = (st_q == S_WDONE);
      st_d   = S_IDLE;
      oe_d   = 1'b0;
    end else begin
      unique case (st_q)
        S_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == LAST) begin
            bit_d = '0;
            st_d  = S_IDLE;
            unique case (ph_q)
              PH_DEV: if (dev_ok) begin
                a8_d  = sh_q[1];
                oe_d  = 1'b1;
                st_d  = S_ACK;
                nxt_d = sh_q[0] ? S_TX : S_RX;
                ph_d  = PH_WADDR;
              end
              PH_WADDR: begin
                wa_d = sh_q;
                if (sh_q == REG_ADDR) begin
                  oe_d  = 1'b1;
                  st_d  = S_ACK;
                  nxt_d = S_RX;
                  ph_d  = PH_WDATA;
                end
              end
              default: begin
                wd_d  = sh_q;
                oe_d  = 1'b1;
                st_d  = S_ACK;
                nxt_d = S_WDONE;
              end
            endcase
          end
        end
        S_ACK: if (scl_fall) begin
          st_d  = nxt_q;
          bit_d = '0;
          if (nxt_q == S_TX) begin
            sh_d = rdata;
            oe_d = ~rdata[BYTE_W-1];
          end else begin
            oe_d = 1'b0;
          end
        end
        S_WDONE: if (scl_fall) st_d = S_IDLE;
        S_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 1'b1;
          end else if (scl_fall) begin
            if (bit_q == LAST) begin
              oe_d  = 1'b0;
              st_d  = S_MACK;
              bit_d = '0;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d = S_TX;
              sh_d = rdata;
              oe_d = ~rdata[BYTE_W-1];
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      nxt_q  <= S_IDLE;
      ph_q   <= PH_DEV;
      bit_q  <= '0;
      sh_q   <= '0;
      oe_q   <= 1'b0;
      a8_q   <= 1'b0;
      mack_q <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_d;
      nxt_q  <= nxt_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      oe_q   <= oe_d;
      a8_q   <= a8_d;
      mack_q <= mack_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
    end
  end

  assign sda_oe = oe_q;
  assign a8     = a8_q;
  assign waddr  = wa_q;
  assign wdata  = wd_q;
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
  import twi_pkg::*;
#(
  parameter int                WEL_BIT  = 1,
  parameter logic [BYTE_W-1:0] REG_ADDR = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              a8,
  input  logic [BYTE_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wp,
  output logic [BYTE_W-1:0] ctrl,
  output logic [BYTE_W-1:0] fault,
  output logic [BYTE_W-1:0] rdata
);
  localparam logic [BYTE_W-1:0] WEL_MASK = BYTE_W'(1) << WEL_BIT;

  logic [BYTE_W-1:0] ctrl_q, ctrl_d, fault_q, fault_d;
  logic              wel, wr_ok, ctrl_en, fault_en;

  assign wel      = ctrl_q[WEL_BIT];
  assign wr_ok    = commit && !wp && (waddr == REG_ADDR);
  assign ctrl_en  = wr_ok && a8;
  assign fault_en = wr_ok && !a8 && wel;

  always_comb begin
    ctrl_d  = wel ? wdata : ((ctrl_q & ~WEL_MASK) | (wdata & WEL_MASK));
    fault_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fault_q <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (fault_en) fault_q <= fault_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign fault = fault_q;
  assign rdata = (waddr != REG_ADDR) ? '1 : (a8 ? ctrl_q : fault_q);
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave
  import twi_pkg::*;
#(
  parameter logic [3:0]        DEV_CODE    = 4'b1011,
  parameter logic [BYTE_W-1:0] REG_ADDR    = 8'hFF,
  parameter int                WEL_BIT     = 1,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wp_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] fault_o
);
  logic [1:0]        rst_q;
  logic              rst_int;
  logic              scl_s_w, sda_s_w, rise_w, fall_w, start_w, stop_w;
  logic              commit_w, a8_w;
  logic [BYTE_W-1:0] waddr_w, wdata_w, rdata_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int = rst_q[1];

  twi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s_w), .sda_s(sda_s_w), .scl_rise(rise_w), .scl_fall(fall_w),
    .start_det(start_w), .stop_det(stop_w)
  );

  twi_frame #(.DEV_CODE(DEV_CODE), .REG_ADDR(REG_ADDR)) u_frame (
    .clk(clk), .rst_n(rst_int), .scl_rise(rise_w), .scl_fall(fall_w),
    .start_det(start_w), .stop_det(stop_w), .sda_s(sda_s_w), .rdata(rdata_w),
    .sda_oe(sda_oe_o), .commit(commit_w), .a8(a8_w), .waddr(waddr_w),
    .wdata(wdata_w)
  );

  twi_regfile #(.WEL_BIT(WEL_BIT), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_int), .commit(commit_w), .a8(a8_w),
    .waddr(waddr_w), .wdata(wdata_w), .wp(wp_i), .ctrl(ctrl_o),
    .fault(fault_o), .rdata(rdata_w)
  );
endmodule

// File: rtl/twi_regslave_chk.sv
module twi_regslave_chk #(
  parameter int WEL_BIT = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_i,
  input logic       sda_oe_o,
  input logic [7:0] ctrl_o,
  input logic [7:0] fault_o,
  input logic       commit,
  input logic       stop,
  input logic       scl_s
);
  // R6
  wp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |=> ($stable(ctrl_o) && $stable(fault_o)));

  // R5
  wel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[WEL_BIT] |=> ($stable(fault_o) &&
      ((ctrl_o & ~(8'd1 << WEL_BIT)) == ($past(ctrl_o) & ~(8'd1 << WEL_BIT)))));

  // R7
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(ctrl_o) && $stable(fault_o)));

  // R7
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> stop);

  // R8
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind twi_regslave twi_regslave_chk #(.WEL_BIT(WEL_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .sda_oe_o(sda_oe_o),
  .ctrl_o(ctrl_o), .fault_o(fault_o), .commit(commit_w), .stop(stop_w),
  .scl_s(scl_s_w)
);

// File: tb/sim_twi_regslave.sv
`timescale 1ns/1ps
module sim_twi_regslave;
  localparam int Q  = 6;
  localparam int WD = 190000;
  localparam int M_NORM = 0, M_PART = 1, M_OVER = 2, M_RST = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic       sda_oe;
  logic [7:0] ctrl, fault;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_ctrl = 8'h00;
  logic [7:0] m_fault = 8'h00;

  always #4 clk = ~clk;

  twi_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .wp_i(wp),
    .sda_oe_o(sda_oe), .ctrl_o(ctrl), .fault_o(fault)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic void model_commit(logic a8, logic [7:0] d, logic p);
    if (p) return;
    if (a8) m_ctrl = m_ctrl[1] ? d : {m_ctrl[7:2], d[1], m_ctrl[0]};
    else if (m_ctrl[1]) m_fault = d;
  endfunction

  function automatic logic [7:0] model_read(logic a8, logic [7:0] wa);
    if (wa != 8'hFF) return 8'hFF;
    return a8 ? m_ctrl : m_fault;
  endfunction

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
  endtask

  task automatic clk_bit(logic b);
    sda_m = b; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q/2);
    ack = ~sda_line;
    tick(Q/2); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1; tick(Q/2);
      d[i] = sda_line;
      tick(Q/2); scl_m = 0;
    end
    tick(Q/2);
    sda_m = ~give_ack; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(Q);
    sda_m = 1;
  endtask

  task automatic do_write(logic a8, logic [7:0] wa, logic [7:0] d, int mode, string tag);
    logic ack;
    bus_start();
    send_byte({4'b1011, 2'b00, a8, 1'b0}, ack);
    check("R2 write slave byte ack", {7'd0, ack}, 8'd1);
    send_byte(wa, ack);
    check("R3 word address ack", {7'd0, ack}, {7'd0, wa == 8'hFF});
    if (mode == M_PART) begin
      for (int i = 0; i < 4; i++) clk_bit(d[7-i]);
      bus_stop();
    end else begin
      send_byte(d, ack);
      if (wa == 8'hFF) check("R4 data byte ack", {7'd0, ack}, 8'd1);
      if (mode == M_OVER) begin
        send_byte(8'h33, ack);
        check("R7 overlong byte not acked", {7'd0, ack}, 8'd0);
        bus_stop();
      end else if (mode == M_RST) begin
        bus_rstart();
        bus_stop();
      end else begin
        bus_stop();
        if (wa == 8'hFF) model_commit(a8, d, wp);
      end
    end
    check({tag, " ctrl"}, ctrl, m_ctrl);
    check({tag, " fault"}, fault, m_fault);
  endtask

  task automatic do_read(logic a8, logic [7:0] wa, int reps, string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1011, 2'b00, a8, 1'b0}, ack);
    check("R2 dummy write ack", {7'd0, ack}, 8'd1);
    send_byte(wa, ack);
    check("R3 dummy address ack", {7'd0, ack}, {7'd0, wa == 8'hFF});
    bus_rstart();
    send_byte({4'b1011, 2'b00, a8, 1'b1}, ack);
    check("R2 read slave byte ack", {7'd0, ack}, 8'd1);
    for (int r = 0; r < reps; r++) begin
      recv_byte(d, r != reps - 1);
      check(tag, d, model_read(a8, wa));
    end
    bus_stop();
    check("R9 SDA released after read", {7'd0, sda_oe}, 8'd0);
  endtask

  task automatic bad_dev(logic [7:0] b);
    logic ack;
    bus_start();
    send_byte(b, ack);
    check("R2 foreign slave byte nack", {7'd0, ack}, 8'd0);
    send_byte(8'hFF, ack);
    check("R2 ignored after foreign byte", {7'd0, ack}, 8'd0);
    bus_stop();
    check("R2 ctrl unchanged", ctrl, m_ctrl);
    check("R2 fault unchanged", fault, m_fault);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1
    check("R1 sda released", {7'd0, sda_oe}, 8'd0);
    check("R1 ctrl reset", ctrl, 8'h00);
    check("R1 fault reset", fault, 8'h00);

    // R5: latch clear, fault write refused, ctrl write only touches bit 1
    do_write(1'b0, 8'hFF, 8'h77, M_NORM, "R5 fault refused");
    do_write(1'b1, 8'hFF, 8'hFF, M_NORM, "R5 only enable bit");
    check("R5 ctrl is 02", ctrl, 8'h02);
    // R4
    do_write(1'b0, 8'hFF, 8'h5A, M_NORM, "R4 fault write");
    do_write(1'b1, 8'hFF, 8'hA6, M_NORM, "R4 ctrl write");
    check("R4 ctrl is A6", ctrl, 8'hA6);
    // R6
    wp = 1'b1;
    tick(2);
    do_write(1'b1, 8'hFF, 8'h00, M_NORM, "R6 ctrl blocked");
    do_write(1'b0, 8'hFF, 8'h11, M_NORM, "R6 fault blocked");
    wp = 1'b0;
    tick(2);
    // R2
    bad_dev(8'hA2);
    bad_dev(8'hB6);
    // R7
    do_write(1'b0, 8'hFF, 8'hC3, M_PART, "R7 partial discarded");
    do_write(1'b0, 8'hFF, 8'hC3, M_OVER, "R7 overlong discarded");
    do_write(1'b0, 8'hFF, 8'hC3, M_RST, "R7 repeated start discarded");
    // R3
    do_write(1'b0, 8'h12, 8'h99, M_NORM, "R3 bad address write");
    do_read(1'b0, 8'h12, 1, "R3 bad address reads FF");
    // R8
    do_read(1'b0, 8'hFF, 1, "R8 read fault");
    do_read(1'b1, 8'hFF, 1, "R8 read ctrl");
    // R9
    do_read(1'b1, 8'hFF, 3, "R9 repeated byte on master ack");

    for (int n = 0; n < 40; n++) begin
      int kind;
      logic a8;
      logic [7:0] wa, d;
      kind = $urandom_range(0, 9);
      a8   = 1'($urandom_range(0, 1));
      wa   = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 254)) : 8'hFF;
      d    = 8'($urandom_range(0, 255));
      wp   = ($urandom_range(0, 4) == 0);
      tick(2);
      if (kind <= 4)      do_write(a8, wa, d, M_NORM, "R4 random write");
      else if (kind == 5) do_write(a8, wa, d, M_PART, "R7 random partial");
      else if (kind == 6) do_write(a8, wa, d, M_OVER, "R7 random overlong");
      else if (kind == 7) do_write(a8, wa, d, M_RST, "R7 random restart");
      else                do_read(a8, wa, 1 + (kind - 8), "R8 random read");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule